// File: doc/BRIEF.md
# Clock Update Cycle Sequencer

This block runs the once-per-second advance of a real-time clock's time and date fields: seconds, minutes, hours, day of week, day of month, month and a two-digit year. A one-cycle pulse on `tick1Hz` from the divider chain starts an update. The sequencer first raises an update-busy status (`uip`). After a fixed lead time it changes the time fields in one step. It keeps the status high for a further settling window, then drops it and sets a sticky update-done flag. That flag can drive an interrupt request.

A freeze input lets software load the clock without any update getting in the way. While freeze is high, ticks are thrown away rather than held back for later. Raising freeze during an update cancels that update. Software loads one field per cycle through a small load port. Each field is held in the data format that software chose: packed BCD or plain binary. The hours field is read as 24-hour or as 12-hour with a PM bit. Register address decoding and reads of the flag live in a separate port block, which drives `flagClr` when the flag is read.

Top module: `rtcUpdateSeq`

## Requirements
- R1: While `rstN` is low, the fields reset to second 0, minute 0, hour 0, weekday 1, day 1, month 1 and year 0. In the same state, `uip`, `updEnded` and `irqReq` are low.
- R2: Suppose a `tick1Hz` pulse is sampled while idle with `setMode` low. Then `uip` is high from the next clock edge, and the time fields change exactly `LEAD_CYC` edges after the tick edge.
- R3: After the fields change, `uip` stays high for `UPD_CYC` more edges. On the last of those edges `uip` falls and `updEnded` sets.
- R4: A tick sampled while `setMode` is high is discarded: no update starts, then or later. If `setMode` rises while `uip` is high, `uip` falls at the next edge. An update cancelled before its change edge leaves the fields unchanged and does not set `updEnded`.
- R5: When `loadEn` and `setMode` are both high, `loadData` is written into the field picked by `loadSel`. The codes are: 0 second, 1 minute, 2 hour, 3 weekday, 4 day, 5 month, 6 year. When `setMode` is low, `loadEn` is ignored.
- R6: With `binMode`=1 the fields count in plain binary. With `binMode`=0 they count in packed BCD, with the tens digit in bits 7:4 and the units digit in bits 3:0.
- R7: Seconds and minutes wrap from 59 to 0 and carry into the next field. In 24-hour mode (`mode24`=1) the hour wraps from 23 to 0 and advances the date.
- R8: In 12-hour mode the hour runs from 1 to 12 in bits 6:0, and bit 7 set means PM. Going from 11 to 12 toggles PM, and going from 12 to 1 keeps it. The date advances only on the step from 11 PM to 12 AM.
- R9: On a date advance, the weekday wraps from 7 to 1 and the month from 12 to 1. The day wraps after the month's last day. April, June, September and November have 30 days. February has 29 days when the year is a multiple of 4 and 28 otherwise. Every other month has 31. The year wraps from 99 to 0.
- R10: `updEnded` holds until a `flagClr` pulse clears it. If setting and clearing fall on the same edge, the set wins.
- R11: `irqReq` is high exactly when `updEnded` and `ueIntEn` are both high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rstN | input | 1 | Active-low synchronous reset |
| tick1Hz | input | 1 | One-cycle pulse that starts an update |
| setMode | input | 1 | Freeze: blocks updates and enables loading |
| binMode | input | 1 | 1 = binary fields, 0 = packed BCD |
| mode24 | input | 1 | 1 = 24-hour, 0 = 12-hour with PM bit |
| ueIntEn | input | 1 | Interrupt enable for the update-done flag |
| flagClr | input | 1 | Clears the update-done flag |
| loadEn | input | 1 | Field load strobe |
| loadSel | input | 3 | Field select for loading |
| loadData | input | 8 | Value to load |
| timeSec | output | 8 | Seconds |
| timeMin | output | 8 | Minutes |
| timeHour | output | 8 | Hours (bit 7 = PM in 12-hour mode) |
| timeDow | output | 8 | Day of week |
| timeDom | output | 8 | Day of month |
| timeMon | output | 8 | Month |
| timeYear | output | 8 | Year within century |
| uip | output | 1 | Update-busy status |
| updEnded | output | 1 | Sticky update-done flag |
| irqReq | output | 1 | Interrupt request |

## Verification
The finishing edge of an update, which sets `updEnded`, can fall on the same edge as a flag read that drives `flagClr`. If clear beat set, one completion event would be lost without trace. The bench counts edges from the tick so that `flagClr` is high exactly on the edge where `uip` falls. It then expects the flag still set and the interrupt request raised. A second collision, a tick arriving together with `setMode`, is judged by seeing no busy status afterwards and unchanged fields.

// File: rtl/rtcSeqPkg.sv
package rtcSeqPkg;

  typedef enum logic [1:0] {ST_IDLE, ST_LEAD, ST_UPD} seqState_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic commit;  // apply the one-second advance
    logic finish;  // update window closed, set done flag
  } updStrobe_t;

  typedef enum logic [2:0] {
    SEL_SEC = 3'd0, SEL_MIN = 3'd1, SEL_HOUR = 3'd2, SEL_DOW = 3'd3,
    SEL_DOM = 3'd4, SEL_MON = 3'd5, SEL_YEAR = 3'd6
  } fieldSel_e;

  function automatic logic [6:0] bcd2bin(input logic [7:0] b);
    return 7'({3'b0, b[7:4]} * 7'd10 + {3'b0, b[3:0]});
  endfunction

  function automatic logic [7:0] bin2bcd(input logic [6:0] v);
    return {4'(v / 7'd10), 4'(v % 7'd10)};
  endfunction

  function automatic logic [6:0] toBin(input logic [7:0] x, input logic isBin);
    return isBin ? x[6:0] : bcd2bin(x);
  endfunction

  function automatic logic [7:0] fromBin(input logic [6:0] v, input logic isBin);
    return isBin ? {1'b0, v} : bin2bcd(v);
  endfunction

  function automatic logic [6:0] monthDays(input logic [6:0] mon, input logic [6:0] yr);
    case (mon)
      7'd2:                      return (yr[1:0] == 2'd0) ? 7'd29 : 7'd28;
      7'd4, 7'd6, 7'd9, 7'd11:   return 7'd30;
      default:                   return 7'd31;
    endcase
  endfunction

endpackage

// File: rtl/rtcSeqCtrl.sv
module rtcSeqCtrl
  import rtcSeqPkg::*;
#(
  parameter int LEAD_CYC = 8,
  parameter int UPD_CYC  = 64
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       tick1Hz,
  input  logic       setMode,
  output updStrobe_t strobe,
  output logic       uip
);

  localparam int CNT_TOP = ((LEAD_CYC > UPD_CYC) ? LEAD_CYC : UPD_CYC) - 1;
  localparam int CW      = (CNT_TOP < 2) ? 1 : $clog2(CNT_TOP + 1);

  seqState_e stateQ;
  logic [CW-1:0] cntQ;
  logic cntZero;

  assign cntZero = (cntQ == '0);

  always_comb begin
    strobe.commit = (stateQ == ST_LEAD) && cntZero && !setMode;
    strobe.finish = (stateQ == ST_UPD)  && cntZero && !setMode;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ <= ST_IDLE;
      cntQ   <= '0;
    end else begin
      case (stateQ)
        ST_IDLE: if (tick1Hz && !setMode) begin
          stateQ <= ST_LEAD;
          cntQ   <= CW'(LEAD_CYC - 1);
        end
        ST_LEAD: if (setMode) stateQ <= ST_IDLE;
          else if (cntZero) begin
            stateQ <= ST_UPD;
            cntQ   <= CW'(UPD_CYC - 1);
          end else cntQ <= cntQ - 1'b1;
        ST_UPD: if (setMode || cntZero) stateQ <= ST_IDLE;
          else cntQ <= cntQ - 1'b1;
        default: stateQ <= ST_IDLE;
      endcase
    end
  end

  assign uip = (stateQ != ST_IDLE);

endmodule

// File: rtl/rtcTimeDatapath.sv
module rtcTimeDatapath
  import rtcSeqPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  updStrobe_t strobe,
  input  logic       setMode,
  input  logic       binMode,
  input  logic       mode24,
  input  logic       flagClr,
  input  logic       loadEn,
  input  logic [2:0] loadSel,
  input  logic [7:0] loadData,
  output logic [7:0] secQ,
  output logic [7:0] minQ,
  output logic [7:0] hourQ,
  output logic [7:0] dowQ,
  output logic [7:0] domQ,
  output logic [7:0] monQ,
  output logic [7:0] yearQ,
  output logic       doneQ
);

  logic [6:0] sB, mB, hB, wB, dB, moB, yB, lastDay;
  logic [6:0] nS, nM, nH, nW, nD, nMo, nY;
  logic pm, nPm, cMin, cHr, cDay, cMon, cYr;
  logic [7:0] secD, minD, hourD, dowD, domD, monD, yearD, hEnc;

  always_comb begin
    sB  = toBin(secQ, binMode);
    mB  = toBin(minQ, binMode);
    hB  = mode24 ? toBin(hourQ, binMode) : toBin({1'b0, hourQ[6:0]}, binMode);
    pm  = hourQ[7];
    wB  = toBin(dowQ, binMode);
    dB  = toBin(domQ, binMode);
    moB = toBin(monQ, binMode);
    yB  = toBin(yearQ, binMode);
    lastDay = monthDays(moB, yB);

    cMin = (sB >= 7'd59);
    nS   = cMin ? 7'd0 : sB + 7'd1;
    cHr  = cMin && (mB >= 7'd59);
    nM   = (mB >= 7'd59) ? 7'd0 : mB + 7'd1;

    nH = hB; nPm = pm; cDay = 1'b0;
    if (mode24) begin
      cDay = cHr && (hB >= 7'd23);
      nH   = (hB >= 7'd23) ? 7'd0 : hB + 7'd1;
    end else if (hB == 7'd11) begin
      nH = 7'd12; nPm = ~pm; cDay = cHr && pm;
    end else if (hB >= 7'd12) begin
      nH = 7'd1;
    end else begin
      nH = hB + 7'd1;
    end

    nW   = (wB >= 7'd7) ? 7'd1 : wB + 7'd1;
    cMon = cDay && (dB >= lastDay);
    nD   = (dB >= lastDay) ? 7'd1 : dB + 7'd1;
    cYr  = cMon && (moB >= 7'd12);
    nMo  = (moB >= 7'd12) ? 7'd1 : moB + 7'd1;
    nY   = (yB >= 7'd99) ? 7'd0 : yB + 7'd1;

    hEnc  = fromBin(nH, binMode);
    secD  = fromBin(nS, binMode);
    minD  = cMin ? fromBin(nM, binMode) : minQ;
    hourD = !cHr ? hourQ : (mode24 ? hEnc : {nPm, hEnc[6:0]});
    dowD  = cDay ? fromBin(nW, binMode) : dowQ;
    domD  = cDay ? fromBin(nD, binMode) : domQ;
    monD  = cMon ? fromBin(nMo, binMode) : monQ;
    yearD = cYr  ? fromBin(nY, binMode) : yearQ;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      secQ <= 8'd0; minQ <= 8'd0; hourQ <= 8'd0;
      dowQ <= 8'd1; domQ <= 8'd1; monQ <= 8'd1; yearQ <= 8'd0;
    end else if (strobe.commit) begin
      secQ <= secD; minQ <= minD; hourQ <= hourD;
      dowQ <= dowD; domQ <= domD; monQ <= monD; yearQ <= yearD;
    end else if (loadEn && setMode) begin
      case (loadSel)
        SEL_SEC:  secQ  <= loadData;
        SEL_MIN:  minQ  <= loadData;
        SEL_HOUR: hourQ <= loadData;
        SEL_DOW:  dowQ  <= loadData;
        SEL_DOM:  domQ  <= loadData;
        SEL_MON:  monQ  <= loadData;
        SEL_YEAR: yearQ <= loadData;
        default: ;
      endcase
    end
  end

  // Done flag: a set on the same edge as a clear takes priority
  always_ff @(posedge clk) begin
    if (!rstN)              doneQ <= 1'b0;
    else if (strobe.finish) doneQ <= 1'b1;
    else if (flagClr)       doneQ <= 1'b0;
  end

endmodule

// File: rtl/rtcUpdateSeq.sv
module rtcUpdateSeq
  import rtcSeqPkg::*;
#(
  parameter int LEAD_CYC = 8,
  parameter int UPD_CYC  = 64
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       tick1Hz,
  input  logic       setMode,
  input  logic       binMode,
  input  logic       mode24,
  input  logic       ueIntEn,
  input  logic       flagClr,
  input  logic       loadEn,
  input  logic [2:0] loadSel,
  input  logic [7:0] loadData,
  output logic [7:0] timeSec,
  output logic [7:0] timeMin,
  output logic [7:0] timeHour,
  output logic [7:0] timeDow,
  output logic [7:0] timeDom,
  output logic [7:0] timeMon,
  output logic [7:0] timeYear,
  output logic       uip,
  output logic       updEnded,
  output logic       irqReq
);

  updStrobe_t strobe;

  rtcSeqCtrl #(.LEAD_CYC(LEAD_CYC), .UPD_CYC(UPD_CYC)) uCtrl (
    .clk(clk), .rstN(rstN), .tick1Hz(tick1Hz), .setMode(setMode),
    .strobe(strobe), .uip(uip)
  );

  rtcTimeDatapath uData (
    .clk(clk), .rstN(rstN), .strobe(strobe), .setMode(setMode),
    .binMode(binMode), .mode24(mode24), .flagClr(flagClr),
    .loadEn(loadEn), .loadSel(loadSel), .loadData(loadData),
    .secQ(timeSec), .minQ(timeMin), .hourQ(timeHour), .dowQ(timeDow),
    .domQ(timeDom), .monQ(timeMon), .yearQ(timeYear), .doneQ(updEnded)
  );

  assign irqReq = updEnded && ueIntEn;

endmodule

// File: rtl/rtcUpdateSeq_chk.sv
module rtcUpdateSeq_chk (
  input logic       clk,
  input logic       rstN,
  input logic       tick1Hz,
  input logic       setMode,
  input logic       loadEn,
  input logic       flagClr,
  input logic       uip,
  input logic       updEnded,
  input logic [7:0] timeSec
);

  AST_SEC_CHANGE_GUARDED: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(timeSec) |-> ($past(uip) || $past(loadEn && setMode))); // R2

  AST_UIP_NEEDS_TICK: assert property (@(posedge clk) disable iff (!rstN)
    $rose(uip) |-> ($past(tick1Hz) && !$past(setMode))); // R2

  AST_FREEZE_DROPS_UIP: assert property (@(posedge clk) disable iff (!rstN)
    setMode |=> !uip); // R4

  AST_FLAG_ON_FINISH: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(uip) && !$past(setMode)) |-> updEnded); // R3

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (updEnded && !flagClr) |=> updEnded); // R10

endmodule

bind rtcUpdateSeq rtcUpdateSeq_chk uChk (
  .clk(clk), .rstN(rstN), .tick1Hz(tick1Hz), .setMode(setMode),
  .loadEn(loadEn), .flagClr(flagClr), .uip(uip), .updEnded(updEnded),
  .timeSec(timeSec)
);

// File: tb/tb_rtcUpdateSeq.sv
module tb_rtcUpdateSeq;

  localparam int LEAD = 8;
  localparam int UPD  = 64;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic tick1Hz = 0, setMode = 0, binMode = 0, mode24 = 1, ueIntEn = 0, flagClr = 0, loadEn = 0;
  logic [2:0] loadSel = 0;
  logic [7:0] loadData = 0;
  logic [7:0] timeSec, timeMin, timeHour, timeDow, timeDom, timeMon, timeYear;
  logic uip, updEnded, irqReq;

  int nChecks = 0, nFail = 0;
  int mS, mM, mH, mPm, mW, mD, mMo, mY;
  bit mBin, m24;

  always #2 clk = ~clk;

  rtcUpdateSeq #(.LEAD_CYC(LEAD), .UPD_CYC(UPD)) dut (
    .clk(clk), .rstN(rstN), .tick1Hz(tick1Hz), .setMode(setMode),
    .binMode(binMode), .mode24(mode24), .ueIntEn(ueIntEn), .flagClr(flagClr),
    .loadEn(loadEn), .loadSel(loadSel), .loadData(loadData),
    .timeSec(timeSec), .timeMin(timeMin), .timeHour(timeHour), .timeDow(timeDow),
    .timeDom(timeDom), .timeMon(timeMon), .timeYear(timeYear),
    .uip(uip), .updEnded(updEnded), .irqReq(irqReq)
  );

  task automatic check(string req, string what, int act, int exp);
    nChecks++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic int enc(int v);
    return mBin ? v : ((v / 10) * 16 + (v % 10));
  endfunction

  function automatic int encHour();
    return m24 ? enc(mH) : ((mPm << 7) | enc(mH));
  endfunction

  function automatic int lastDay(int mo, int y);
    if (mo == 2) return (y % 4 == 0) ? 29 : 28;
    if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
    return 31;
  endfunction

  task automatic modelAdvance();
    bit dayCarry;
    dayCarry = 0;
    mS++;
    if (mS == 60) begin
      mS = 0; mM++;
      if (mM == 60) begin
        mM = 0;
        if (m24) begin
          mH++;
          if (mH == 24) begin mH = 0; dayCarry = 1; end
        end else if (mH == 11) begin
          mH = 12; dayCarry = (mPm == 1); mPm = 1 - mPm;
        end else if (mH == 12) mH = 1;
        else mH++;
      end
    end
    if (dayCarry) begin
      mW = (mW == 7) ? 1 : mW + 1;
      if (mD >= lastDay(mMo, mY)) begin
        mD = 1;
        if (mMo == 12) begin mMo = 1; mY = (mY == 99) ? 0 : mY + 1; end
        else mMo++;
      end else mD++;
    end
  endtask

  task automatic checkTime(string req);
    check(req, "sec",  timeSec,  enc(mS));
    check(req, "min",  timeMin,  enc(mM));
    check(req, "hour", timeHour, encHour());
    check(req, "dow",  timeDow,  enc(mW));
    check(req, "dom",  timeDom,  enc(mD));
    check(req, "mon",  timeMon,  enc(mMo));
    check(req, "year", timeYear, enc(mY));
  endtask

  task automatic setModel(int s, int m, int h, int pm, int w, int d, int mo, int y, bit b, bit h24);
    mS = s; mM = m; mH = h; mPm = pm; mW = w; mD = d; mMo = mo; mY = y; mBin = b; m24 = h24;
  endtask

  task automatic loadModel(bit keepSet);
    @(negedge clk);
    setMode = 1; binMode = mBin; mode24 = m24;
    for (int sel = 0; sel < 7; sel++) begin
      loadEn = 1; loadSel = 3'(sel);
      case (sel)
        0: loadData = 8'(enc(mS));
        1: loadData = 8'(enc(mM));
        2: loadData = 8'(encHour());
        3: loadData = 8'(enc(mW));
        4: loadData = 8'(enc(mD));
        5: loadData = 8'(enc(mMo));
        default: loadData = 8'(enc(mY));
      endcase
      @(negedge clk);
    end
    loadEn = 0;
    setMode = keepSet;
  endtask

  // Tick, count edges, check the change edge and the finishing edge
  task automatic runUpdate(string req, bit clrAtEnd);
    int oldSec;
    @(negedge clk) flagClr = 1;
    @(negedge clk) flagClr = 0;
    oldSec = timeSec;
    tick1Hz = 1;
    @(negedge clk) tick1Hz = 0;
    check("R2", "uip after tick", uip, 1);
    repeat (LEAD - 1) @(negedge clk);
    check("R2", "sec before change edge", timeSec, oldSec);
    @(negedge clk);
    modelAdvance();
    checkTime(req);
    repeat (UPD - 1) @(negedge clk);
    check("R3", "uip before finish", uip, 1);
    check("R3", "flag before finish", updEnded, 0);
    flagClr = clrAtEnd;
    @(negedge clk) flagClr = 0;
    check("R3", "uip after finish", uip, 0);
    check(clrAtEnd ? "R10" : "R3", "flag after finish", updEnded, 1);
    check("R11", "irq", irqReq, ueIntEn);
  endtask

  initial begin
    #(4 * 150000);
    nFail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", nChecks, nFail);
    $finish;
  end

  initial begin
    int seed;
    seed = 32'h1f3a;
    void'($urandom(seed));
    repeat (3) @(negedge clk);
    check("R1", "sec", timeSec, 0);   check("R1", "hour", timeHour, 0);
    check("R1", "dow", timeDow, 1);   check("R1", "dom", timeDom, 1);
    check("R1", "mon", timeMon, 1);   check("R1", "year", timeYear, 0);
    check("R1", "uip", uip, 0);       check("R1", "flag", updEnded, 0);
    check("R1", "irq", irqReq, 0);
    rstN = 1;

    // R5: load without freeze is ignored
    @(negedge clk) loadEn = 1; loadSel = 3'd0; loadData = 8'h33;
    @(negedge clk) loadEn = 0;
    check("R5", "sec unchanged", timeSec, 0);

    // Full rollover, BCD 24h, tick during freeze discarded
    setModel(59, 59, 23, 0, 7, 31, 12, 99, 0, 1);
    loadModel(1);
    checkTime("R5");
    tick1Hz = 1;
    @(negedge clk) tick1Hz = 0;
    @(negedge clk) setMode = 0;
    repeat (3) @(negedge clk);
    check("R4", "no uip from frozen tick", uip, 0);
    checkTime("R4");
    ueIntEn = 1;
    runUpdate("R9", 0);
    @(negedge clk) flagClr = 1;
    @(negedge clk) flagClr = 0;
    check("R10", "flag cleared", updEnded, 0);
    check("R11", "irq low", irqReq, 0);

    // Abort before change edge
    tick1Hz = 1;
    @(negedge clk) tick1Hz = 0;
    @(negedge clk) setMode = 1;
    @(negedge clk);
    check("R4", "uip dropped", uip, 0);
    repeat (LEAD + UPD + 2) @(negedge clk);
    setMode = 0;
    checkTime("R4");
    check("R4", "no flag", updEnded, 0);

    // Set and clear on the same edge
    setModel(10, 0, 5, 0, 3, 5, 6, 20, 1, 1);
    loadModel(0);
    runUpdate("R6", 1);

    setModel(59, 59, 23, 0, 2, 28, 2, 23, 1, 1); loadModel(0); runUpdate("R9", 0);
    setModel(59, 59, 23, 0, 2, 28, 2, 24, 1, 1); loadModel(0); runUpdate("R9", 0);
    setModel(59, 59, 23, 0, 4, 30, 4, 24, 0, 1); loadModel(0); runUpdate("R9", 0);
    setModel(59, 59, 9, 0, 1, 1, 1, 0, 0, 1);    loadModel(0); runUpdate("R7", 0);
    setModel(59, 59, 11, 1, 5, 15, 3, 10, 0, 0); loadModel(0); runUpdate("R8", 0);
    setModel(59, 59, 12, 1, 5, 15, 3, 10, 0, 0); loadModel(0); runUpdate("R8", 0);
    setModel(59, 59, 11, 0, 5, 15, 3, 10, 1, 0); loadModel(0); runUpdate("R8", 0);

    for (int i = 0; i < 40; i++) begin
      bit h24;
      int mo, y;
      h24 = 1'($urandom);
      mo = 1 + int'($urandom % 12);
      y = int'($urandom % 100);
      setModel(($urandom % 3 == 0) ? 59 : int'($urandom % 60),
               ($urandom % 2 == 0) ? 59 : int'($urandom % 60),
               h24 ? int'($urandom % 24) : 1 + int'($urandom % 12),
               int'($urandom % 2), 1 + int'($urandom % 7),
               1 + int'($urandom % lastDay(mo, y)), mo, y, 1'($urandom), h24);
      ueIntEn = 1'($urandom);
      loadModel(0);
      runUpdate("R6", 0);
    end

    $display("  [TB] %0d tests run, %0d failed", nChecks, nFail);
    $finish;
  end

endmodule